// File: doc/BRIEF.md
# Strided Masked Vector Address Generator

This block turns one long-vector memory operand into a stream of per-element accesses. A single start strobe captures a base byte address, a signed element stride, the operand size in bytes, an inclusive range of register element indices (first and last) out of a 64-element register, and an optional 64-bit mask. From the next cycle on, the block presents one element per clock. Each element has its memory byte address, the register element index it pairs with, and a flag that says whether the element takes part or is masked off.

The stride counts operand-sized steps, not bytes. A stride of one walks a packed vector, a negative stride walks downwards, and a stride of zero repeats one scalar address for every element. The memory vector always begins at the base address, whatever the first register index is. Masked-off elements still use their slot in the sequence and in memory. A one-cycle done pulse closes each operation.

Top module: `vec_stride_agen`

## Requirements
- R1: After reset, elem_valid_o, elem_active_o and done_o are all low.
- R2: When start_i is accepted in cycle k with first_i <= last_i, cycle k+1 presents the first element: elem_valid_o=1, elem_idx_o=first_i, elem_addr_o=base_i.
- R3: The element at position j of the range (j=0 at first_i) has address base_i + j * sign_extend(stride_i) * size_i, taken modulo 2^ADDR_W. Negative strides and address wrap-around follow this formula.
- R4: With stride_i = 0, every element of the operation carries the same address, base_i.
- R5: Valid elements appear on consecutive cycles, and elem_idx_o rises by exactly one per cycle from first_i to last_i inclusive. The memory position j is counted from the start of the range, not from register index 0.
- R6: With mask_en_i=0 every element is active, whatever mask_i holds. With mask_en_i=1, elem_active_o equals mask_i[elem_idx_o] (bit i belongs to register element i), and the first element may itself be inactive.
- R7: In the cycle after the element with index last_i, done_o is high for exactly one cycle and elem_valid_o is low.
- R8: If first_i > last_i, no element is produced, and done_o pulses in the cycle after start is accepted.
- R9: start_i is accepted only while elem_valid_o is low. A start during a running operation does not change its elements.
- R10: elem_active_o is low whenever elem_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; operand fields are sampled with it |
| base_i | input | ADDR_W (32) | Effective byte address of memory element 0 |
| stride_i | input | STRIDE_W (16) | Signed stride in units of the operand size |
| size_i | input | SIZE_W (4) | Operand size in bytes |
| first_i | input | IDX_W (6) | First register element index |
| last_i | input | IDX_W (6) | Last register element index (inclusive) |
| mask_en_i | input | 1 | Apply mask_i when high |
| mask_i | input | NUM_ELEM (64) | Per-register-element enable bits |
| elem_valid_o | output | 1 | An element is presented this cycle |
| elem_addr_o | output | ADDR_W (32) | Byte address of the element |
| elem_idx_o | output | IDX_W (6) | Register element index of the element |
| elem_active_o | output | 1 | Element takes part (not masked off) |
| done_o | output | 1 | One-cycle pulse ending an operation |

## Verification
The bench targets several corner cases:
- A range that does not start at zero. A design that offset memory by the first index would give every address a constant error.
- Negative strides, and wrap-around past the top of the address space. Sign or width mistakes in the stride scaling would show up here.
- A zero stride, which must stay on one address.
- A single-element range whose only element is masked off, and a reversed range that must finish with no elements at all.
- An all-zero mask with masking disabled, where a design that ignored the enable would drop every element.
- A start strobe during a running operation, which a design that restarted would use to corrupt the index and address stream.

// File: rtl/vagen_pkg.sv
package vagen_pkg;
    localparam int VA_ADDR_W   = 32;
    localparam int VA_STRIDE_W = 16;
    localparam int VA_SIZE_W   = 4;
    localparam int VA_NUM_ELEM = 64;
endpackage

// File: rtl/vagen_step.sv
module vagen_step #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int SIZE_W   = 4
) (
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [SIZE_W-1:0]   size_i,
    output logic [ADDR_W-1:0]   step_o
);
    localparam int EXT_W = ADDR_W - STRIDE_W;
    localparam int PAD_W = ADDR_W - SIZE_W;

    logic signed [ADDR_W-1:0] stride_ext;
    logic signed [ADDR_W-1:0] size_ext;

    // byte step = signed element stride scaled by operand size, modulo 2^ADDR_W
    assign stride_ext = {{EXT_W{stride_i[STRIDE_W-1]}}, stride_i};
    assign size_ext   = {{PAD_W{1'b0}}, size_i};
    assign step_o     = stride_ext * size_ext;
endmodule

// File: rtl/vagen_mask_pick.sv
module vagen_mask_pick #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] idx_i,
    output logic          bit_o
);
    assign bit_o = vec_i[idx_i];
endmodule

// File: rtl/vec_stride_agen.sv
module vec_stride_agen
    import vagen_pkg::*;
#(
    parameter int ADDR_W   = VA_ADDR_W,
    parameter int STRIDE_W = VA_STRIDE_W,
    parameter int SIZE_W   = VA_SIZE_W,
    parameter int NUM_ELEM = VA_NUM_ELEM,
    localparam int IDX_W   = $clog2(NUM_ELEM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [STRIDE_W-1:0] stride_i,
    input  logic [SIZE_W-1:0]   size_i,
    input  logic [IDX_W-1:0]    first_i,
    input  logic [IDX_W-1:0]    last_i,
    input  logic                mask_en_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    output logic                elem_valid_o,
    output logic [ADDR_W-1:0]   elem_addr_o,
    output logic [IDX_W-1:0]    elem_idx_o,
    output logic                elem_active_o,
    output logic                done_o
);
    typedef struct packed {
        logic                valid;
        logic                active;
        logic                done;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    last;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   step;
        logic [NUM_ELEM-1:0] mask;
    } agen_state_t;

    agen_state_t st_q, st_d;

    logic [ADDR_W-1:0]   step_w;
    logic [NUM_ELEM-1:0] pick_vec;
    logic [IDX_W-1:0]    pick_idx;
    logic                pick_bit;

    vagen_step #(
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W),
        .SIZE_W   (SIZE_W)
    ) u_step (
        .stride_i (stride_i),
        .size_i   (size_i),
        .step_o   (step_w)
    );

    // one selector serves both the loading cycle and the advancing cycles
    assign pick_vec = st_q.valid ? st_q.mask : (mask_en_i ? mask_i : '1);
    assign pick_idx = st_q.valid ? IDX_W'(st_q.idx + 1'b1) : first_i;

    vagen_mask_pick #(
        .N (NUM_ELEM)
    ) u_pick (
        .vec_i (pick_vec),
        .idx_i (pick_idx),
        .bit_o (pick_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.valid) begin
            if (st_q.idx == st_q.last) begin
                st_d.valid  = 1'b0;
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.idx    = IDX_W'(st_q.idx + 1'b1);
                st_d.addr   = st_q.addr + st_q.step;
                st_d.active = pick_bit;
            end
        end else if (start_i) begin
            st_d.last = last_i;
            st_d.step = step_w;
            st_d.mask = mask_en_i ? mask_i : '1;
            if (first_i > last_i) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.valid  = 1'b1;
                st_d.idx    = first_i;
                st_d.addr   = base_i;
                st_d.active = pick_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elem_valid_o  = st_q.valid;
    assign elem_addr_o   = st_q.addr;
    assign elem_idx_o    = st_q.idx;
    assign elem_active_o = st_q.active;
    assign done_o        = st_q.done;
endmodule

// File: rtl/vagen_checker.sv
module vagen_checker #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16,
    parameter int IDX_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [STRIDE_W-1:0] stride_i,
    input logic                elem_valid_o,
    input logic [ADDR_W-1:0]   elem_addr_o,
    input logic [IDX_W-1:0]    elem_idx_o,
    input logic                elem_active_o,
    input logic                done_o
);
    logic zero_stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_stride_q <= 1'b0;
        end else if (start_i && !elem_valid_o) begin
            zero_stride_q <= (stride_i == '0);
        end
    end

    // R5: consecutive elements step the register index by one
    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid_o && $past(elem_valid_o) |-> elem_idx_o == IDX_W'($past(elem_idx_o) + 1'b1));

    // R4: zero stride keeps the address fixed
    a_r4_scalar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid_o && $past(elem_valid_o) && zero_stride_q |-> elem_addr_o == $past(elem_addr_o));

    // R7: the element stream always ends in a done pulse
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(elem_valid_o) |-> done_o);

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done and valid never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({elem_valid_o, done_o}));

    // R10: active only with a presented element
    a_r10_active_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid_o |-> !elem_active_o);

    // R9: a running operation continues regardless of start
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid_o && start_i && !done_o |=> elem_valid_o || done_o);
endmodule

bind vec_stride_agen vagen_checker #(
    .ADDR_W   (ADDR_W),
    .STRIDE_W (STRIDE_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stride_i      (stride_i),
    .elem_valid_o  (elem_valid_o),
    .elem_addr_o   (elem_addr_o),
    .elem_idx_o    (elem_idx_o),
    .elem_active_o (elem_active_o),
    .done_o        (done_o)
);

// File: tb/sim_vec_stride_agen.sv
module sim_vec_stride_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] stride_i = '0;
    logic [3:0]  size_i = '0;
    logic [5:0]  first_i = '0;
    logic [5:0]  last_i = '0;
    logic        mask_en_i = 1'b0;
    logic [63:0] mask_i = '0;
    logic        elem_valid_o;
    logic [31:0] elem_addr_o;
    logic [5:0]  elem_idx_o;
    logic        elem_active_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    always #2 clk = ~clk;

    vec_stride_agen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .base_i        (base_i),
        .stride_i      (stride_i),
        .size_i        (size_i),
        .first_i       (first_i),
        .last_i        (last_i),
        .mask_en_i     (mask_en_i),
        .mask_i        (mask_i),
        .elem_valid_o  (elem_valid_o),
        .elem_addr_o   (elem_addr_o),
        .elem_idx_o    (elem_idx_o),
        .elem_active_o (elem_active_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Expected stream built from the requirements; poke_at >= 0 fires a stray start at that element.
    task automatic run_op(input logic [31:0] base, input int stride, input int size,
                          input int first, input int last, input bit men,
                          input logic [63:0] mask, input int poke_at);
        int          n;
        logic [31:0] ea;
        bit          ex_act;
        n = (first > last) ? 0 : last - first + 1;
        base_i = base; stride_i = 16'(stride); size_i = 4'(size);
        first_i = 6'(first); last_i = 6'(last); mask_en_i = men; mask_i = mask;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int j = 0; j < n; j++) begin
            ea = base + 32'(longint'(j) * longint'(stride) * longint'(size));
            ex_act = men ? mask[first + j] : 1'b1;
            chk(elem_valid_o === 1'b1, (j == 0) ? "R2 valid" : "R5 valid", 64'(elem_valid_o), 64'd1);
            chk(elem_idx_o === 6'(first + j), "R5 idx", 64'(elem_idx_o), 64'(first + j));
            chk(elem_addr_o === ea, (stride == 0) ? "R4 addr" : "R3 addr", 64'(elem_addr_o), 64'(ea));
            chk(elem_active_o === ex_act, "R6 active", 64'(elem_active_o), 64'(ex_act));
            chk(done_o === 1'b0, "R7 done early", 64'(done_o), 64'd0);
            if (j == poke_at) begin
                start_i = 1'b1; base_i = ~base; stride_i = 16'h7; first_i = 6'd0; last_i = 6'd1;
            end
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        chk(done_o === 1'b1, (n == 0) ? "R8 done" : "R7 done", 64'(done_o), 64'd1);
        chk(elem_valid_o === 1'b0, (n == 0) ? "R8 no elem" : "R7 valid low", 64'(elem_valid_o), 64'd0);
        chk(elem_active_o === 1'b0, "R10 active low", 64'(elem_active_o), 64'd0);
        @(posedge clk); #1;
        chk(done_o === 1'b0, "R7 pulse", 64'(done_o), 64'd0);
        chk(elem_valid_o === 1'b0 && elem_active_o === 1'b0, "R10 idle",
            {62'd0, elem_valid_o, elem_active_o}, 64'd0);
    endtask

    initial begin
        #200000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(elem_valid_o === 1'b0 && done_o === 1'b0 && elem_active_o === 1'b0, "R1 reset",
            {61'd0, elem_valid_o, done_o, elem_active_o}, 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R2 R3 R5: unit stride, doubleword, from element 0
        run_op(32'h0000_1000, 1, 8, 0, 7, 1'b0, 64'd0, -1);
        // R3 R6: negative stride, range not at zero, masked
        run_op(32'h0004_0000, -3, 4, 10, 20, 1'b1, 64'hA5A5_F00F_3C3C_1234, -1);
        // R4: scalar broadcast
        run_op(32'h0000_2222, 0, 2, 5, 9, 1'b1, 64'h0000_0000_0000_0140, -1);
        // R8: reversed range
        run_op(32'h0000_0100, 1, 4, 9, 3, 1'b0, 64'd0, -1);
        // R6: single masked-off element at the top index
        run_op(32'h0000_0800, 1, 8, 63, 63, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, -1);
        // R9 R6: full range with a stray start
        run_op(32'h0010_0000, 2, 1, 0, 63, 1'b1, 64'h5555_5555_5555_5555, 1);
        // R6: mask disabled with all-zero mask
        run_op(32'h0000_3000, 1, 2, 4, 11, 1'b0, 64'd0, -1);
        // R3: wrap past top of address space
        run_op(32'hFFFF_FFF0, 1, 8, 0, 3, 1'b0, 64'd0, -1);
        // R3: most negative stride with odd size
        run_op(32'h0000_0000, -32768, 3, 30, 32, 1'b0, 64'd0, -1);
        finish_run();
    end
endmodule